// File: doc/BRIEF.md
# Status Packet Serializer

This block turns a parallel status word into a short packet on an 8-bit byte-serial status bus. Whenever the status word changes, or a send command arrives, it raises a request toward the downstream bus owner. It then holds a fixed address byte on the bus until an acknowledge input is seen. The acknowledge marks the cycle in which the address byte is taken. The payload bytes follow on consecutive cycles, one per clock.

The first payload byte combines a 6-bit sequence tag with the two lowest status bits. The sequence tag is the value given with the most recent send command, so a reply can be matched to the query that asked for it. The remaining status bits follow in 8-bit slices, lowest slice first. The status word is captured at the acknowledge, so all bytes of one packet describe the same instant. A change that arrives too late to be in the current packet sets a pending flag, and that flag starts one further packet.

The block uses one clock and a synchronous active-low reset. A parameter chooses whether the status input is registered before change detection and capture.

Top module: `status_packet_tx`

## Requirements
- R1: During reset and directly after it, with status_in held at zero and no command, pkt_req is 0 and pkt_byte is 8'h00.
- R2: With REG_INPUT=1, a change on status_in made after clock edge N shows as pkt_req=1 after edge N+2. With REG_INPUT=0, it shows after edge N+1.
- R3: A send_req pulse raises pkt_req even when the status has not changed. The packet it produces carries send_seq in bits [7:2] of the first payload byte.
- R4: Once raised, pkt_req stays at 1 until a cycle with pkt_ack=1. In every cycle where pkt_req=1, pkt_byte equals ADDR_BYTE.
- R5: pkt_req is 0 in the cycle after the acknowledge cycle and in every cycle of that packet's payload.
- R6: Over the four cycles after the acknowledge cycle, pkt_byte carries four bytes in this order: {seq[5:0], status[1:0]}, then status[9:2], then status[17:10], then status[25:18].
- R7: The payload is taken from the status value present at the acknowledge edge. Changes made while the request is waiting are included. Changes made during the payload do not alter that packet.
- R8: A status change or command that is sampled in the acknowledge cycle or during the payload produces exactly one further packet after the current one.
- R9: pkt_byte is 8'h00 in every cycle in which no request is raised and no payload byte is being sent.
- R10: The sequence tag keeps the value from the last send command. Later packets caused by status changes carry that same value.
- R11: With a constant status and no command, pkt_req stays at 0.
- R12: A change sampled at the edge that ends the last payload byte leads straight to pkt_req=1, with ADDR_BYTE on the bus in the next cycle and no idle cycle between the packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| status_in | input | STATUS_W | Parallel status word to report |
| send_req | input | 1 | One-cycle command to send a packet |
| send_seq | input | 6 | Sequence tag that comes with the command |
| pkt_byte | output | 8 | Byte-serial bus: address byte, then payload, otherwise zero |
| pkt_req | output | 1 | Request to send a packet |
| pkt_ack | input | 1 | Downstream accepts the address byte in this cycle |

## Verification
The bench uses STATUS_W=26, which gives the full four-byte payload, so the top slice status[25:18] is checked. It also uses REG_INPUT=1, so the extra input register stage is part of every latency it checks: the request rising two edges after a change, and the exact payload cycle in which a late change turns into a back-to-back request. The acknowledge delay can be set, which covers both a long wait with the address byte held and an acknowledge on the first possible cycle. The fixed address byte 8'hA5 is non-zero, so a held address byte cannot be confused with an idle bus.

// File: rtl/stpkt_pkg.sv
// Shared constants, state type and sizing helper for the status packet serializer.
// Assumes an 8-bit bus and a first payload byte of {6-bit tag, 2 low status bits}.
package stpkt_pkg;
    localparam int BYTE_W = 8;
    localparam int SEQ_W  = 6;
    localparam int LOW_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;

    // Number of payload bytes: one tag byte plus the slices of the upper status bits.
    function automatic int payload_bytes(input int status_w);
        return 1 + (status_w - LOW_W + BYTE_W - 1) / BYTE_W;
    endfunction
endpackage

// File: rtl/stpkt_capture.sv
// Status front end: an optional input register and change detection.
// Assumes status_in is synchronous to clk. After reset the reference value is zero,
// so a non-zero status at reset release counts as a change.
module stpkt_capture #(
    parameter int STATUS_W  = 26,
    parameter bit REG_INPUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_in,
    output logic [STATUS_W-1:0] status_cur,
    output logic                changed
);
    logic [STATUS_W-1:0] prev_q;

    generate
        if (REG_INPUT) begin : g_reg
            // Register the incoming status word.
            always_ff @(posedge clk) begin
                if (!rst_n) status_cur <= '0;
                else        status_cur <= status_in;
            end
        end else begin : g_direct
            assign status_cur = status_in;
        end
    endgenerate

    // Keep the value seen in the previous cycle for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= status_cur;
    end

    assign changed = (status_cur != prev_q);
endmodule

// File: rtl/stpkt_ctrl.sv
// Handshake sequencer: idle, request raised, payload in progress.
// Holds the pending flag for events that arrive while a packet is on its way.
// Assumes the acknowledge is only given while the request is raised.
module stpkt_ctrl
    import stpkt_pkg::*;
#(
    parameter int NPAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic changed,
    input  logic send_req,
    input  logic ack,
    output logic req,
    output logic load,
    output logic advance,
    output logic req_next
);
    localparam int CNT_W = $clog2(NPAY + 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pend_q, pend_d;
    logic             evt;

    assign evt = changed | send_req;

    // Work out the next state, the byte counter and the pending flag.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt) state_d = ST_REQ;
            end
            ST_REQ: begin
                if (ack) begin
                    state_d = ST_SEND;
                    cnt_d   = CNT_W'(NPAY - 1);
                    pend_d  = evt;
                end
            end
            ST_SEND: begin
                if (cnt_q == '0) begin
                    state_d = (pend_q | evt) ? ST_REQ : ST_IDLE;
                    pend_d  = 1'b0;
                end else begin
                    cnt_d  = cnt_q - 1'b1;
                    pend_d = pend_q | evt;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register the state, the counter and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    assign req      = (state_q == ST_REQ);
    assign load     = (state_q == ST_REQ) && ack;
    assign advance  = (state_q == ST_SEND) && (cnt_q != '0);
    assign req_next = (state_d == ST_REQ);
endmodule

// File: rtl/stpkt_shifter.sv
// Packet datapath: sequence tag register, payload snapshot and shift, bus register.
// Assumes load and advance never occur in the same cycle.
module stpkt_shifter
    import stpkt_pkg::*;
#(
    parameter int          STATUS_W  = 26,
    parameter int          NPAY      = 4,
    parameter logic [7:0]  ADDR_BYTE = 8'hA5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_cur,
    input  logic                send_req,
    input  logic [SEQ_W-1:0]    send_seq,
    input  logic                load,
    input  logic                advance,
    input  logic                req_next,
    output logic [BYTE_W-1:0]   bus
);
    localparam int PAY_W = NPAY * BYTE_W;
    localparam int EXT_W = PAY_W - SEQ_W;

    logic [SEQ_W-1:0] seq_q;
    logic [EXT_W-1:0] st_ext;
    logic [PAY_W-1:0] pay;
    logic [PAY_W-1:0] sh_q;

    assign st_ext = EXT_W'(status_cur);
    assign pay    = {st_ext[EXT_W-1:LOW_W], seq_q, st_ext[LOW_W-1:0]};

    // Keep the tag from the latest send command.
    always_ff @(posedge clk) begin
        if (!rst_n)        seq_q <= '0;
        else if (send_req) seq_q <= send_seq;
    end

    // Capture the payload at the acknowledge and shift out one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (load)    sh_q <= pay >> BYTE_W;
        else if (advance) sh_q <= sh_q >> BYTE_W;
    end

    // Drive the bus: payload byte, held address byte, or zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus <= '0;
        else if (load)     bus <= pay[BYTE_W-1:0];
        else if (advance)  bus <= sh_q[BYTE_W-1:0];
        else if (req_next) bus <= ADDR_BYTE;
        else               bus <= '0;
    end
endmodule

// File: rtl/status_packet_tx.sv
// Status packet serializer top: front end, sequencer and datapath.
// Assumes one clock domain and that pkt_ack is only given while pkt_req is high.
module status_packet_tx
    import stpkt_pkg::*;
#(
    parameter int         STATUS_W  = 26,
    parameter bit         REG_INPUT = 1'b1,
    parameter logic [7:0] ADDR_BYTE = 8'hA5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_in,
    input  logic                send_req,
    input  logic [5:0]          send_seq,
    output logic [7:0]          pkt_byte,
    output logic                pkt_req,
    input  logic                pkt_ack
);
    localparam int NPAY = payload_bytes(STATUS_W);

    logic [STATUS_W-1:0] status_cur;
    logic                changed, load, advance, req_next;

    stpkt_capture #(.STATUS_W(STATUS_W), .REG_INPUT(REG_INPUT)) u_capture (
        .clk(clk), .rst_n(rst_n), .status_in(status_in),
        .status_cur(status_cur), .changed(changed)
    );

    stpkt_ctrl #(.NPAY(NPAY)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .changed(changed), .send_req(send_req),
        .ack(pkt_ack), .req(pkt_req), .load(load), .advance(advance),
        .req_next(req_next)
    );

    stpkt_shifter #(.STATUS_W(STATUS_W), .NPAY(NPAY), .ADDR_BYTE(ADDR_BYTE)) u_shifter (
        .clk(clk), .rst_n(rst_n), .status_cur(status_cur), .send_req(send_req),
        .send_seq(send_seq), .load(load), .advance(advance),
        .req_next(req_next), .bus(pkt_byte)
    );
endmodule

// File: rtl/stpkt_checker.sv
// Protocol checker for the serializer bus, attached to the top by bind.
// Counts payload cycles itself from the handshake seen at the ports.
module stpkt_checker
    import stpkt_pkg::*;
#(
    parameter int         STATUS_W  = 26,
    parameter logic [7:0] ADDR_BYTE = 8'hA5
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pkt_byte,
    input logic       pkt_req,
    input logic       pkt_ack
);
    localparam int NPAY = payload_bytes(STATUS_W);
    localparam int CW   = $clog2(NPAY + 1);

    logic [CW-1:0] left_q;

    // Payload cycles still to come after an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  left_q <= '0;
        else if (pkt_req && pkt_ack) left_q <= CW'(NPAY);
        else if (left_q != '0)       left_q <= left_q - 1'b1;
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && !pkt_ack) |=> pkt_req);
    assert_addr_on_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req |-> (pkt_byte == ADDR_BYTE));
    assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && pkt_ack) |=> !pkt_req);
    assert_no_req_in_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q != '0) |-> !pkt_req);
    assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((left_q == '0) && !pkt_req) |-> (pkt_byte == 8'h00));
endmodule

bind status_packet_tx stpkt_checker #(.STATUS_W(STATUS_W), .ADDR_BYTE(ADDR_BYTE)) u_stpkt_chk (
    .clk(clk), .rst_n(rst_n), .pkt_byte(pkt_byte), .pkt_req(pkt_req), .pkt_ack(pkt_ack)
);

// File: tb/test_status_packet_tx.sv
// Scoreboard bench: driver tasks queue expected payloads, a monitor compares them.
module test_status_packet_tx;
    localparam int         SW   = 26;
    localparam logic [7:0] ADDR = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [SW-1:0] status_in = '0;
    logic        send_req = 1'b0;
    logic [5:0]  send_seq = '0;
    logic [7:0]  pkt_byte;
    logic        pkt_req;
    logic        pkt_ack = 1'b0;

    int          n_chk = 0;
    int          n_fail = 0;
    int          ack_gap = 0;
    logic [31:0] exp_q[$];
    logic [5:0]  cur_seq = '0;
    event        ack_seen;

    always #10 clk = ~clk;

    status_packet_tx #(.STATUS_W(SW), .REG_INPUT(1'b1), .ADDR_BYTE(ADDR)) i_status_packet_tx (
        .clk(clk), .rst_n(rst_n), .status_in(status_in), .send_req(send_req),
        .send_seq(send_seq), .pkt_byte(pkt_byte), .pkt_req(pkt_req), .pkt_ack(pkt_ack)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pay(input logic [SW-1:0] st, input logic [5:0] sq);
        return {st[25:2], sq, st[1:0]};
    endfunction

    task automatic set_status(input logic [SW-1:0] v);
        @(posedge clk); #2 status_in = v;
    endtask

    task automatic push(input logic [SW-1:0] st);
        exp_q.push_back(exp_pay(st, cur_seq));
    endtask

    task automatic send_cmd(input logic [5:0] s);
        @(posedge clk); #2 send_req = 1'b1; send_seq = s; cur_seq = s;
        @(posedge clk); #2 send_req = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    // Responder: acknowledges a raised request after ack_gap cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pkt_req) begin
                repeat (ack_gap) @(negedge clk);
                @(posedge clk); #2 pkt_ack = 1'b1;
                @(posedge clk); #2 pkt_ack = 1'b0;
            end
        end
    end

    // Monitor: checks the handshake and compares each payload with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pkt_req && !pkt_ack)
                check(pkt_byte == ADDR, "R4 address byte held", 32'(pkt_byte), 32'(ADDR));
            if (rst_n && pkt_req && pkt_ack) begin
                logic [31:0] got;
                logic [31:0] exp;
                check(pkt_byte == ADDR, "R4 address at ack", 32'(pkt_byte), 32'(ADDR));
                -> ack_seen;
                got = '0;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    check(!pkt_req, "R5 request low in payload", 32'(pkt_req), 32'd0);
                    got[k*8 +: 8] = pkt_byte;
                end
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected packet", got, 32'd0);
                end else begin
                    exp = exp_q.pop_front();
                    check(got == exp, "R6 R7 payload", got, exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(!pkt_req && pkt_byte == 8'h00, "R1 in reset", {23'd0, pkt_req, pkt_byte}, 32'd0);
        @(posedge clk); #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!pkt_req && pkt_byte == 8'h00, "R1 after reset", {23'd0, pkt_req, pkt_byte}, 32'd0);

        // R11: no event, no request
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!pkt_req, "R11 quiet", 32'(pkt_req), 32'd0);
        end

        // R2 latency, R6 layout
        set_status(26'h2AB_CDEF); push(26'h2AB_CDEF);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(pkt_req, "R2 request after two edges", 32'(pkt_req), 32'd1);
        drain();
        // R9: quiet bus between packets
        check(pkt_byte == 8'h00 && !pkt_req, "R9 idle bus", {23'd0, pkt_req, pkt_byte}, 32'd0);

        // R3: command without a status change
        send_cmd(6'h2A); push(26'h2AB_CDEF);
        drain();

        // R10: tag kept for a change-driven packet
        set_status(26'h155_5555); push(26'h155_5555);
        drain();

        // R4 and R7: long wait, change while waiting is included
        ack_gap = 6;
        set_status(26'h0F0_F0F0);
        repeat (3) @(posedge clk);
        set_status(26'h3FF_FFFF); push(26'h3FF_FFFF);
        drain();
        ack_gap = 0;

        // R7 and R8: change during payload goes to the next packet
        send_cmd(6'h3F); push(26'h3FF_FFFF);
        @(ack_seen);
        @(posedge clk); #2 status_in = 26'h012_3456; push(26'h012_3456);
        drain();
        check(!pkt_req && pkt_byte == 8'h00, "R8 single follow-up", {23'd0, pkt_req, pkt_byte}, 32'd0);

        // R12: change in the last payload cycle, back-to-back request
        set_status(26'h2C3_A5E1); push(26'h2C3_A5E1);
        @(ack_seen);
        @(posedge clk); @(posedge clk); @(posedge clk);
        #2 status_in = 26'h1D2_B4C7; push(26'h1D2_B4C7);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(pkt_req && pkt_byte == ADDR, "R12 back-to-back request",
              {23'd0, pkt_req, pkt_byte}, {23'd0, 1'b1, ADDR});
        drain();

        // R11: quiet again at the end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!pkt_req && pkt_byte == 8'h00, "R11 R9 final quiet", {23'd0, pkt_req, pkt_byte}, 32'd0);
        end
        check(exp_q.size() == 0, "R8 all packets seen", 32'(exp_q.size()), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule